// File: doc/BRIEF.md
# I2C Bus Hang Timeout Monitor

This block watches a serial bus for a hang, meaning that some uncontrolled device holds the clock or data line low and the transfer engine can no longer make progress. The host writes one 8-bit timeout register, which is never read back. Its top bit turns the watchdog on, and its low seven bits give the timeout value V. A down-counter reloads with V every time SCL changes level. It counts down on a prescaled tick only while SCL stays low. When the count runs out, the monitor stops watching and raises an interrupt. It also reports the stuck-clock status code 90H and pulses a reset to the serial engine, which sends the engine back to idle.

When the counter expires while the host is asking for a START and the bus is busy, the monitor also pulses a force-start request so that the START can be pushed onto the bus. Reading the status acknowledges the event. If both lines are high again at that read, the monitor goes back to watching. If either line is still low, the monitor latches a request for an external reset and stays there until `rst_n` is asserted.

The states are WATCH, EXPIRED and STUCK. The transitions are:
- WATCH to EXPIRED on counter expiry.
- EXPIRED to WATCH on a status read with the bus free.
- EXPIRED to STUCK on a status read while the bus is still obstructed.
- STUCK is left only through reset.

Top module: `hang_monitor`

## Requirements
- R1: A write to the timeout register takes bit 7 as the enable and bits 6:0 as the timeout value V. The write also restarts the count.
- R2: With the enable set, expiry happens on the (V+1)-th tick that arrives while SCL is low and has not changed level in that cycle. A tick in the cycle where SCL falls does not count. With V=0, the first such tick expires the counter.
- R3: While SCL is high, and in any cycle where it changes level, the count reloads to V, so a clock that keeps toggling never causes expiry.
- R4: With the enable clear, the counter is held at V and never expires, however long SCL stays low.
- R5: After reset, `status` is F8H and `irq`, `eng_rst`, `force_start` and `ext_rst_req` are all 0. From the cycle after expiry, `irq` is 1 and `status` is 90H.
- R6: `eng_rst` is a single-cycle pulse in the cycle after expiry.
- R7: A status read in EXPIRED with both SCL and SDA high returns the monitor to WATCH, with `irq` at 0 and `status` at F8H. A status read in EXPIRED with SCL or SDA low enters STUCK, where `ext_rst_req` is 1, `irq` is 0 and `status` stays 90H. STUCK is left only by reset, and further reads or a released bus do not change it.
- R8: `force_start` pulses for one cycle together with `eng_rst` only when `sta_req` and `bus_busy` are both high in the expiry cycle. At any other time it stays 0.
- R9: A status read while in WATCH has no effect on any output.
- R10: The count is held at V while the monitor is not in WATCH. After a return to WATCH, the full V+1 ticks are needed again before expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| to_wr | input | 1 | Write strobe for the timeout register |
| to_wdata | input | 8 | Timeout register data: bit 7 is the enable, bits 6:0 are V |
| stat_rd | input | 1 | Host status-read strobe |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| sta_req | input | 1 | Host START request |
| bus_busy | input | 1 | Bus-busy indication from the engine |
| status | output | 8 | Status code: 90H on a hang, F8H otherwise |
| irq | output | 1 | Interrupt, high in EXPIRED |
| eng_rst | output | 1 | One-cycle reset pulse to the serial engine |
| force_start | output | 1 | One-cycle forced-START pulse |
| ext_rst_req | output | 1 | Obstruction persisted after the status read |

## Verification
The bench checks the exact expiry tick for V=3 and V=0, and with sparse ticks. A design that is off by one, or that counts the tick in the cycle where SCL falls, would raise `irq` one cycle early or late. A clock that keeps toggling with short low phases, and a disabled watchdog with SCL held low, must never expire. A counter that failed to reload on SCL edges, or ignored the enable, would interrupt in those cases. The bench also performs status reads with the bus free, with only SDA low, and while still in WATCH. A design that resolved the release wrongly would fail to latch STUCK, leave STUCK early, or react to a spurious read. Finally, the force-start pulse is checked both with and without a pending START request.

// File: rtl/hang_monitor_pkg.sv
package hang_monitor_pkg;
    typedef enum logic [1:0] {
        HM_WATCH   = 2'd0,
        HM_EXPIRED = 2'd1,
        HM_STUCK   = 2'd2
    } hm_state_e;

    localparam logic [7:0] STAT_HANG = 8'h90;
    localparam logic [7:0] STAT_IDLE = 8'hF8;
endpackage

// File: rtl/hang_cfg_reg.sv
module hang_cfg_reg #(
    parameter int TO_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [TO_W:0]   wdata_i,
    output logic            en_o,
    output logic [TO_W-1:0] val_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o  <= 1'b0;
            val_o <= '0;
        end else if (wr_i) begin
            en_o  <= wdata_i[TO_W];
            val_o <= wdata_i[TO_W-1:0];
        end
    end
endmodule

// File: rtl/hang_counter.sv
module hang_counter #(
    parameter int TO_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [TO_W-1:0] val_i,
    input  logic            wr_i,
    input  logic [TO_W-1:0] wval_i,
    input  logic            arm_i,
    input  logic            scl_i,
    input  logic            tick_i,
    output logic            expire_o
);
    logic [TO_W-1:0] cnt_q;
    logic            scl_q;
    logic            toggle;
    logic            run;

    assign toggle   = scl_i ^ scl_q;
    assign run      = en_i && arm_i && !wr_i && !scl_i && !toggle;
    assign expire_o = run && tick_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_i) begin
            cnt_q <= wval_i;
        end else if (!run) begin
            cnt_q <= val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !wr_i) |=> (cnt_q == $past(val_i))) else $error("counter not held"); // R4

    AST_RELOAD_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && !wr_i) |=> (cnt_q == $past(val_i))) else $error("counter not reloaded"); // R3
endmodule

// File: rtl/hang_fsm.sv
module hang_fsm
    import hang_monitor_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire_i,
    input  logic       rd_i,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       sta_req_i,
    input  logic       busy_i,
    output logic       arm_o,
    output logic       irq_o,
    output logic [7:0] status_o,
    output logic       eng_rst_o,
    output logic       force_o,
    output logic       ext_rst_o
);
    hm_state_e state_q, state_d;
    logic      obstructed;

    assign obstructed = !scl_i || !sda_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HM_WATCH:   if (expire_i) state_d = HM_EXPIRED;
            HM_EXPIRED: if (rd_i)     state_d = obstructed ? HM_STUCK : HM_WATCH;
            HM_STUCK:   state_d = HM_STUCK;
            default:    state_d = HM_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HM_WATCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_rst_o <= 1'b0;
            force_o   <= 1'b0;
        end else begin
            eng_rst_o <= (state_q == HM_WATCH) && expire_i;
            force_o   <= (state_q == HM_WATCH) && expire_i && sta_req_i && busy_i;
        end
    end

    always_comb begin
        arm_o     = (state_q == HM_WATCH);
        irq_o     = (state_q == HM_EXPIRED);
        ext_rst_o = (state_q == HM_STUCK);
        status_o  = (state_q == HM_WATCH) ? STAT_IDLE : STAT_HANG;
    end

    AST_EXPIRE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(!scl_i)) else $error("expiry with SCL high"); // R2

    AST_ENG_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst_o |=> !eng_rst_o) else $error("engine reset too long"); // R6

    AST_IRQ_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> eng_rst_o) else $error("irq without engine reset"); // R6

    AST_FORCE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        force_o |-> $past(sta_req_i && busy_i)) else $error("spurious force"); // R8

    AST_STUCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_o |=> ext_rst_o) else $error("left stuck state"); // R7
endmodule

// File: rtl/hang_monitor.sv
module hang_monitor #(
    parameter int TO_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            to_wr,
    input  logic [TO_W:0]   to_wdata,
    input  logic            stat_rd,
    input  logic            scl_in,
    input  logic            sda_in,
    input  logic            sta_req,
    input  logic            bus_busy,
    output logic [7:0]      status,
    output logic            irq,
    output logic            eng_rst,
    output logic            force_start,
    output logic            ext_rst_req
);
    logic            te;
    logic [TO_W-1:0] to_val;
    logic            arm;
    logic            expire;

    hang_cfg_reg #(.TO_W(TO_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (to_wr),
        .wdata_i (to_wdata),
        .en_o    (te),
        .val_o   (to_val)
    );

    hang_counter #(.TO_W(TO_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (te),
        .val_i    (to_val),
        .wr_i     (to_wr),
        .wval_i   (to_wdata[TO_W-1:0]),
        .arm_i    (arm),
        .scl_i    (scl_in),
        .tick_i   (tick),
        .expire_o (expire)
    );

    hang_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire_i  (expire),
        .rd_i      (stat_rd),
        .scl_i     (scl_in),
        .sda_i     (sda_in),
        .sta_req_i (sta_req),
        .busy_i    (bus_busy),
        .arm_o     (arm),
        .irq_o     (irq),
        .status_o  (status),
        .eng_rst_o (eng_rst),
        .force_o   (force_start),
        .ext_rst_o (ext_rst_req)
    );

    AST_EN_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(te)) else $error("expiry while disabled"); // R4
endmodule

// File: tb/hang_monitor_bench.sv
module hang_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       to_wr = 1'b0;
    logic [7:0] to_wdata = 8'h00;
    logic       stat_rd = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       sta_req = 1'b0;
    logic       bus_busy = 1'b0;
    logic [7:0] status;
    logic       irq, eng_rst, force_start, ext_rst_req;

    always #2.5 clk = ~clk;

    hang_monitor u_hang_monitor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .to_wr(to_wr), .to_wdata(to_wdata),
        .stat_rd(stat_rd), .scl_in(scl_in), .sda_in(sda_in), .sta_req(sta_req),
        .bus_busy(bus_busy), .status(status), .irq(irq), .eng_rst(eng_rst),
        .force_start(force_start), .ext_rst_req(ext_rst_req)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R5";

    // behavioural reference: state 0 watching, 1 expired, 2 stuck
    int m_state = 0;
    int m_low_ticks = 0;
    int m_v = 0;
    bit m_te = 0;
    bit m_scl_prev = 1;
    bit e_eng = 0;
    bit e_force = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_low_ticks = 0; m_v = 0; m_te = 0; m_scl_prev = 1;
            e_eng = 0; e_force = 0;
        end else begin
            bit tog, exp_now;
            tog = (scl_in != m_scl_prev);
            exp_now = 0;
            e_eng = 0; e_force = 0;
            if (m_state == 0 && m_te && !to_wr && !scl_in && !tog) begin
                if (tick) begin
                    if (m_low_ticks == m_v) exp_now = 1;
                    else m_low_ticks++;
                end
            end else begin
                m_low_ticks = 0;
            end
            if (exp_now) begin
                m_state = 1; e_eng = 1; e_force = sta_req && bus_busy;
            end else if (m_state == 1 && stat_rd) begin
                m_state = (!scl_in || !sda_in) ? 2 : 0;
            end
            if (to_wr) begin m_te = to_wdata[7]; m_v = int'(to_wdata[6:0]); end
            m_scl_prev = scl_in;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", cur_req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("status", int'(status), (m_state == 0) ? 32'hF8 : 32'h90);
            chk("irq", int'(irq), (m_state == 1) ? 1 : 0);
            chk("eng_rst", int'(eng_rst), int'(e_eng));
            chk("force_start", int'(force_start), int'(e_force));
            chk("ext_rst_req", int'(ext_rst_req), (m_state == 2) ? 1 : 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_to(input logic [7:0] d);
        to_wr = 1'b1; to_wdata = d; @(negedge clk); to_wr = 1'b0;
    endtask

    task automatic rd_stat();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    initial begin
        tick = 1'b1;
        idle(3);
        cur_req = "R5";
        chk("reset status R5", int'(status), 32'hF8);
        chk("reset irq R5", int'(irq), 0);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R1";
        wr_to(8'h83);
        cur_req = "R3";
        idle(20);
        for (int k = 0; k < 10; k++) begin
            scl_in = 1'b0; idle(3); scl_in = 1'b1; idle(2);
        end

        cur_req = "R2";
        scl_in = 1'b0;
        idle(4);
        chk("no irq before V+1 ticks R2", int'(irq), 0);
        @(negedge clk);
        chk("irq at V+1 ticks R2", int'(irq), 1);
        cur_req = "R6";
        idle(3);
        cur_req = "R10";
        idle(10);
        cur_req = "R7";
        scl_in = 1'b1;
        @(negedge clk);
        rd_stat();
        chk("back to watch R7", int'(status), 32'hF8);
        cur_req = "R9";
        rd_stat(); rd_stat();
        idle(3);

        cur_req = "R4";
        wr_to(8'h05);
        scl_in = 1'b0;
        idle(60);
        chk("disabled no irq R4", int'(irq), 0);
        scl_in = 1'b1;
        idle(2);

        cur_req = "R8";
        wr_to(8'h82);
        sta_req = 1'b1; bus_busy = 1'b1;
        scl_in = 1'b0;
        for (int i = 0; i < 30; i++) begin
            tick = (i % 3 == 0); @(negedge clk);
        end
        tick = 1'b1;
        chk("forced start expiry R8", int'(irq), 1);
        sta_req = 1'b0; bus_busy = 1'b0;

        cur_req = "R7";
        scl_in = 1'b1; sda_in = 1'b0;
        idle(2);
        rd_stat();
        chk("stuck latched R7", int'(ext_rst_req), 1);
        sda_in = 1'b1;
        rd_stat();
        idle(5);
        chk("stuck holds R7", int'(ext_rst_req), 1);

        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        cur_req = "R2";
        wr_to(8'h80);
        scl_in = 1'b0;
        @(negedge clk);
        chk("V0 no irq on falling edge R2", int'(irq), 0);
        @(negedge clk);
        chk("V0 irq after first tick R2", int'(irq), 1);
        idle(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule